// File: doc/BRIEF.md
# Debug breakpoint request router

This block sits between a debug state sequencer, a trace recorder and two processors: a main CPU and a coprocessor. When the sequencer signals that it has reached its final state, the block decides which processors receive a breakpoint request. If a trace session is running, that decision is held back until the trace completes. The coprocessor can also raise its own software breakpoint. The block forwards that request to the main CPU when a control bit allows it.

For the main CPU, the block also picks the kind of breakpoint. It is either an entry into background debug mode or a software interrupt. The choice depends on a select bit and on whether background debug is enabled.

A six-bit control register is reached over a small byte-wide register bus. Two of its bits choose which of four comparator banks answers in an eight-byte window, and which of four status registers answers at one address just below that window. The block drives one-hot chip selects for both. All breakpoint outputs are single-cycle pulses, registered one clock after the event that causes them.

Top module: `dbg_brk_router`

## Requirements
- R1: After reset, the control register reads 0. No breakpoint pulse is active. An access inside the window selects bank 0.
- R2: A write at address 0x21 loads the control register from bus_wdata. The bit layout is [1:0] target, [3:2] bank, [4] debug-mode select, [5] coprocessor software-breakpoint enable. A read at 0x21 returns the register zero-extended to 8 bits. Every other address reads 0.
- R3: The target field routes a sequencer breakpoint as follows: 00 to nobody, 01 to the coprocessor only, 10 to the main CPU only, 11 to both.
- R4: While trace_on is 0, an armed final_evt causes the routed pulses on the clock after the event.
- R5: While trace_on is 1, an armed final_evt is held pending. It produces its pulses on the clock after the next trace_done, and not before.
- R6: When armed is 0, a pending breakpoint is discarded and final_evt is ignored.
- R7: cop_swbp raises a main CPU breakpoint only when the enable bit is 1, whatever the target field holds. It never pulses cop_brk.
- R8: A main CPU breakpoint becomes cpu_bdm when the select bit and bdm_en are both 1. It becomes cpu_swi when bdm_en is 0. It is dropped when the select bit is 0 and bdm_en is 1.
- R9: A sequencer breakpoint and a coprocessor software breakpoint in the same cycle give a single one-cycle main CPU pulse.
- R10: An access (bus_rd or bus_wr) to 0x28..0x2F asserts the one bit of cmp_cs given by the bank field. Otherwise cmp_cs is 0.
- R11: An access to 0x27 asserts the one bit of aux_cs given by the bank field. Bits 0..2 select the sequencer state registers and bit 3 selects the match-flag register. Otherwise aux_cs is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Register bus byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 6 | Write data for the control fields |
| bus_rdata | output | 8 | Read data |
| cmp_cs | output | 4 | One-hot comparator bank select for the window |
| aux_cs | output | 4 | One-hot select for the register at 0x27 |
| armed | input | 1 | Sequencer armed; low discards pending work |
| final_evt | input | 1 | Sequencer reached its final state |
| trace_on | input | 1 | A trace session is active |
| trace_done | input | 1 | The trace session has completed |
| cop_swbp | input | 1 | Coprocessor software breakpoint request |
| bdm_en | input | 1 | Background debug is enabled |
| cop_brk | output | 1 | Breakpoint pulse to the coprocessor |
| cpu_bdm | output | 1 | Main CPU pulse: enter background debug |
| cpu_swi | output | 1 | Main CPU pulse: software interrupt |

## Verification
The hardest state to reach is a breakpoint pending behind a running trace that then meets a second event. That second event can be a disarm, a new final_evt in the same cycle as trace_done, or a coprocessor request in the firing cycle. The stimulus drives these combinations first as directed sequences. It then runs a long random phase in which final_evt, trace_on and trace_done are frequent enough that pending breakpoints often overlap disarms and coprocessor requests. A bench model tracks the pending flag and predicts every pulse.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
    localparam int CTRL_W    = 6;
    localparam int NUM_BANKS = 4;

    typedef struct packed {
        logic       swbp_en;
        logic       bdm_sel;
        logic [1:0] bank;
        logic [1:0] tgt;
    } ctrl_t;

    localparam logic [1:0] TGT_NONE = 2'b00;
    localparam logic [1:0] TGT_COP  = 2'b01;
    localparam logic [1:0] TGT_CPU  = 2'b10;
    localparam logic [1:0] TGT_BOTH = 2'b11;
endpackage

// File: rtl/dbg_brk_regs.sv
module dbg_brk_regs
    import dbg_brk_pkg::*;
#(
    parameter int             AW        = 6,
    parameter int             DW        = 8,
    parameter int             WIN_BYTES = 8,
    parameter logic [AW-1:0]  CTRL_ADDR = 6'h21,
    parameter logic [AW-1:0]  WIN_BASE  = 6'h28,
    parameter logic [AW-1:0]  AUX_ADDR  = 6'h27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [CTRL_W-1:0] bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output ctrl_t             ctrl,
    output logic [NUM_BANKS-1:0] cmp_cs,
    output logic [NUM_BANKS-1:0] aux_cs
);
    localparam int WIN_LSB = $clog2(WIN_BYTES);

    typedef struct packed {
        ctrl_t ctrl;
    } state_t;

    state_t s_d, s_q;
    logic   access;
    logic   ctrl_hit;
    logic   win_hit;
    logic   aux_hit;

    assign access   = bus_rd | bus_wr;
    assign ctrl_hit = (bus_addr == CTRL_ADDR);
    assign win_hit  = (bus_addr[AW-1:WIN_LSB] == WIN_BASE[AW-1:WIN_LSB]);
    assign aux_hit  = (bus_addr == AUX_ADDR);

    always_comb begin
        s_d = s_q;
        if (bus_wr && ctrl_hit) begin
            s_d.ctrl = ctrl_t'(bus_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl      = s_q.ctrl;
    assign bus_rdata = ctrl_hit ? {{(DW-CTRL_W){1'b0}}, s_q.ctrl} : '0;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
        assign cmp_cs[b] = access && win_hit && (s_q.ctrl.bank == b[1:0]);
        assign aux_cs[b] = access && aux_hit && (s_q.ctrl.bank == b[1:0]);
    end

    // R2
    ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_ADDR) |=> (s_q.ctrl == $past(bus_wdata)));
    // R10
    cmp_cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmp_cs));
    // R11
    aux_cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((|aux_cs) && (|cmp_cs)));
endmodule

// File: rtl/dbg_brk_seq.sv
module dbg_brk_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic final_evt,
    input  logic trace_on,
    input  logic trace_done,
    output logic fire,
    output logic pending
);
    typedef struct packed {
        logic pend;
    } state_t;

    state_t s_d, s_q;
    logic   fire_c;

    always_comb begin
        s_d    = s_q;
        fire_c = 1'b0;
        if (!armed) begin
            s_d.pend = 1'b0;
        end else begin
            if (s_q.pend && trace_done) begin
                fire_c   = 1'b1;
                s_d.pend = 1'b0;
            end
            if (final_evt) begin
                if (trace_on) begin
                    s_d.pend = 1'b1;
                end else begin
                    fire_c = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fire    = fire_c;
    assign pending = s_q.pend;

    // R6
    disarm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !pending);
    // R5
    trace_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && final_evt && trace_on) |=> pending);
endmodule

// File: rtl/dbg_brk_out.sv
module dbg_brk_out
    import dbg_brk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  logic  fire,
    input  logic  cop_swbp,
    input  logic  bdm_en,
    output logic  cop_brk,
    output logic  cpu_bdm,
    output logic  cpu_swi
);
    typedef struct packed {
        logic cop;
        logic bdm;
        logic swi;
    } state_t;

    state_t s_d, s_q;
    logic   cpu_req;

    always_comb begin
        cpu_req = (fire && ctrl.tgt[1]) || (cop_swbp && ctrl.swbp_en);
        s_d.cop = fire && ctrl.tgt[0];
        s_d.bdm = cpu_req && ctrl.bdm_sel && bdm_en;
        s_d.swi = cpu_req && !bdm_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cop_brk = s_q.cop;
    assign cpu_bdm = s_q.bdm;
    assign cpu_swi = s_q.swi;

    // R8
    cpu_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_bdm, cpu_swi}));
    // R8
    bdm_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_bdm) |-> $past(bdm_en));
    // R3
    cop_needs_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cop_brk |-> $past(ctrl.tgt[0]));
    // R7
    swbp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_swbp && ctrl.swbp_en && !bdm_en) |=> cpu_swi);
endmodule

// File: rtl/dbg_brk_router.sv
module dbg_brk_router
    import dbg_brk_pkg::*;
#(
    parameter int            AW        = 6,
    parameter int            DW        = 8,
    parameter int            WIN_BYTES = 8,
    parameter logic [AW-1:0] CTRL_ADDR = 6'h21,
    parameter logic [AW-1:0] WIN_BASE  = 6'h28,
    parameter logic [AW-1:0] AUX_ADDR  = 6'h27
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [CTRL_W-1:0]    bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic [NUM_BANKS-1:0] cmp_cs,
    output logic [NUM_BANKS-1:0] aux_cs,
    input  logic                 armed,
    input  logic                 final_evt,
    input  logic                 trace_on,
    input  logic                 trace_done,
    input  logic                 cop_swbp,
    input  logic                 bdm_en,
    output logic                 cop_brk,
    output logic                 cpu_bdm,
    output logic                 cpu_swi
);
    ctrl_t ctrl;
    logic  fire;
    logic  pending;

    dbg_brk_regs #(
        .AW(AW), .DW(DW), .WIN_BYTES(WIN_BYTES),
        .CTRL_ADDR(CTRL_ADDR), .WIN_BASE(WIN_BASE), .AUX_ADDR(AUX_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl(ctrl), .cmp_cs(cmp_cs), .aux_cs(aux_cs)
    );

    dbg_brk_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .armed(armed), .final_evt(final_evt),
        .trace_on(trace_on), .trace_done(trace_done),
        .fire(fire), .pending(pending)
    );

    dbg_brk_out u_out (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .fire(fire),
        .cop_swbp(cop_swbp), .bdm_en(bdm_en),
        .cop_brk(cop_brk), .cpu_bdm(cpu_bdm), .cpu_swi(cpu_swi)
    );

    // R5
    no_early_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && armed && !trace_done && !(final_evt && !trace_on)) |=> !cop_brk);
    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_swi && !$past(cop_swbp && ctrl.swbp_en) && !$past(fire)) |-> 1'b0);
endmodule

// File: tb/sim_dbg_brk_router.sv
module sim_dbg_brk_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] cmp_cs, aux_cs;
    logic       armed = 1'b0, final_evt = 1'b0, trace_on = 1'b0, trace_done = 1'b0;
    logic       cop_swbp = 1'b0, bdm_en = 1'b0;
    logic       cop_brk, cpu_bdm, cpu_swi;

    int tests = 0, fails = 0, cycles = 0;
    logic [5:0] m_ctrl = '0;
    logic       m_pend = 1'b0;

    always #2 clk = ~clk;

    dbg_brk_router u0 (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cs(input logic hit);
        return ((bus_rd || bus_wr) && hit) ? (4'b0001 << m_ctrl[3:2]) : 4'b0000;
    endfunction

    // Applies the inputs set by the caller for one clock and checks all outputs.
    task automatic step(input string tag);
        logic fire, req, e_cop, e_bdm, e_swi, n_pend;
        logic [5:0] n_ctrl;
        #1;
        chk("R2", bus_rdata, (bus_addr == 6'h21) ? {2'b00, m_ctrl} : 8'h00);
        chk("R10", cmp_cs, exp_cs(bus_addr[5:3] == 3'b101));
        chk("R11", aux_cs, exp_cs(bus_addr == 6'h27));
        fire = 1'b0; n_pend = m_pend;
        if (!armed) n_pend = 1'b0;
        else begin
            if (m_pend && trace_done) begin fire = 1'b1; n_pend = 1'b0; end
            if (final_evt) begin
                if (trace_on) n_pend = 1'b1; else fire = 1'b1;
            end
        end
        req   = (fire && m_ctrl[1]) || (cop_swbp && m_ctrl[5]);
        e_cop = fire && m_ctrl[0];
        e_bdm = req && m_ctrl[4] && bdm_en;
        e_swi = req && !bdm_en;
        n_ctrl = (bus_wr && bus_addr == 6'h21) ? bus_wdata : m_ctrl;
        @(posedge clk);
        @(negedge clk);
        m_ctrl = n_ctrl;
        m_pend = n_pend;
        chk(tag, {29'd0, cop_brk, cpu_bdm, cpu_swi}, {29'd0, e_cop, e_bdm, e_swi});
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; final_evt = 0; trace_done = 0; cop_swbp = 0;
    endtask

    task automatic wr_ctrl(input logic [5:0] v);
        idle(); bus_wr = 1; bus_addr = 6'h21; bus_wdata = v;
        step("R2");
        idle();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        bus_addr = 6'h21; bus_rd = 1;
        #1 chk("R1", bus_rdata, 8'h00);
        bus_addr = 6'h2c;
        #1 chk("R1", cmp_cs, 4'b0001);
        chk("R1", {cop_brk, cpu_bdm, cpu_swi}, 3'b000);
        @(negedge clk);
        idle(); armed = 1;

        // R2: readback and unmapped address
        wr_ctrl(6'h3f);
        bus_rd = 1; bus_addr = 6'h21; step("R2");
        bus_addr = 6'h10; step("R2");
        idle();

        // R3/R4: target encodings, trace off
        for (int t = 0; t < 4; t++) begin
            wr_ctrl({4'b0000, t[1:0]});
            final_evt = 1; trace_on = 0; bdm_en = 0; step("R3");
            idle(); step("R4");
        end

        // R5: pending behind trace
        wr_ctrl(6'b000011);
        final_evt = 1; trace_on = 1; step("R5");
        idle(); step("R5"); step("R5");
        trace_done = 1; step("R5");
        idle(); step("R5");

        // R6: disarm discards pending; ignored final_evt
        final_evt = 1; trace_on = 1; step("R6");
        idle(); armed = 0; step("R6");
        armed = 1; trace_done = 1; step("R6");
        idle(); armed = 0; final_evt = 1; trace_on = 0; step("R6");
        idle(); armed = 1; step("R6");

        // R7: software breakpoint gating, independent of target
        wr_ctrl(6'b000000);
        cop_swbp = 1; step("R7");
        idle();
        wr_ctrl(6'b100000);
        cop_swbp = 1; step("R7");
        idle(); step("R7");

        // R8: debug-mode resolution
        for (int k = 0; k < 4; k++) begin
            wr_ctrl({1'b1, k[1], 4'b0000});
            bdm_en = k[0]; cop_swbp = 1; step("R8");
            idle(); step("R8");
        end

        // R9: simultaneous sources
        wr_ctrl(6'b100010);
        bdm_en = 0; trace_on = 0; final_evt = 1; cop_swbp = 1; step("R9");
        idle(); step("R9");

        // R10/R11: bank sweep
        for (int b = 0; b < 4; b++) begin
            wr_ctrl({2'b00, b[1:0], 2'b00});
            bus_rd = 1; bus_addr = 6'h28 + 6'(b); step("R10");
            bus_addr = 6'h27; step("R11");
            bus_addr = 6'h30; step("R10");
            idle();
        end

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            armed      = ($urandom % 8) != 0;
            final_evt  = ($urandom % 4) == 0;
            trace_on   = ($urandom % 2) == 0;
            trace_done = ($urandom % 4) == 0;
            cop_swbp   = ($urandom % 6) == 0;
            bdm_en     = ($urandom % 2) == 0;
            bus_rd     = ($urandom % 2) == 0;
            bus_wr     = ($urandom % 10) == 0;
            bus_addr   = (($urandom % 3) == 0) ? 6'h21 : 6'(6'h20 + ($urandom % 16));
            bus_wdata  = 6'($urandom);
            step("R3/R4/R5/R6/R7/R8/R9");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule